// File: doc/BRIEF.md
# USB Endpoint Transmit Control Register

This block holds the transmit-side control state of a single full-speed USB endpoint or host channel. The state is a data-toggle bit, a two-bit transmit status and a four-bit endpoint or channel address. Software reaches the register through a byte-wide register port. The toggle and status bits cannot be loaded directly. Writing 1 to one of them inverts it, and writing 0 leaves it as it is. Software can therefore set a known value by reading the register and then writing back the difference.

The transaction engine also changes the toggle and status fields through single-cycle event inputs. The effect of each event depends on the endpoint type and on whether the block works in host or device mode:
- An acknowledged IN packet advances the toggle.
- A received SETUP forces DATA1 on a control endpoint.
- On an isochronous endpoint, the toggle flips after each packet as a buffer selector.
- A correct transfer in device mode parks the status at NAK.
- In host mode, the status field records the handshake the device returned.

Top module: `usb_ep_tx_ctrl`

## Requirements
- R1: After reset the read value is 0x00: toggle 0 (DATA0), status 00 (DISABLED), address 0.
- R2: On a register write with the byte strobe set, wdata bit 6 = 1 inverts the toggle and wdata bits 5:4 invert the matching status bits. Zero bits, and writes without the strobe, change nothing. Status codes: 00 DISABLED, 01 STALL, 10 NAK, 11 VALID.
- R3: The address is bits 3:0 and takes wdata[3:0] on every strobed write.
- R4: For a non-isochronous endpoint type (00 bulk, 01 control, 11 interrupt), an ACK event inverts the toggle.
- R5: On a control endpoint (type 01), a SETUP event sets the toggle to 1. It takes priority over a simultaneous ACK.
- R6: On an isochronous endpoint (type 10), a packet-sent event inverts the toggle. An ACK event has no effect on the toggle.
- R7: In device mode, on a non-isochronous endpoint, a correct-transfer event sets the status to NAK (10).
- R8: On an isochronous endpoint in device mode, a correct-transfer event leaves the status unchanged.
- R9: In host mode, a handshake-valid event loads the supplied 2-bit code into the status. A correct-transfer event does not force NAK in host mode.
- R10: When a hardware update and a software write hit the same bit in one cycle, the hardware result is computed first and the software inversion is applied to it.
- R11: The read data is {0, toggle, status[1:0], address[3:0]}. All fields update one clock after the event or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write |
| reg_be_i | input | 1 | Byte strobe for the register byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| ep_type_i | input | 2 | 00 bulk, 01 control, 10 isochronous, 11 interrupt |
| host_mode_i | input | 1 | 1 = host channel, 0 = device endpoint |
| ack_rcvd_i | input | 1 | ACK received after a transmitted data packet |
| setup_rcvd_i | input | 1 | SETUP PID addressed to this endpoint |
| iso_sent_i | input | 1 | Isochronous data packet finished |
| xfer_ok_i | input | 1 | Correct transfer completed |
| hs_valid_i | input | 1 | Host mode: handshake captured |
| hs_code_i | input | 2 | Host mode: captured handshake status code |
| dtog_o | output | 1 | Current data toggle |
| stat_o | output | 2 | Current transmit status |
| addr_o | output | 4 | Current address |

## Verification
Directed sequences run each event alone under every endpoint type and both modes. These separate the type qualification: an ACK on an isochronous endpoint and a correct transfer in host mode must both do nothing. Paired events, such as SETUP with ACK, or an event in the same cycle as a toggle write, separate the priority and ordering rules from a plain OR of the updates. A long pseudo-random phase then drives every input at once and compares against a behavioural model on every clock. This catches interactions the directed cases miss.

// File: rtl/usb_ep_tx_pkg.sv
package usb_ep_tx_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int STAT_W   = 2;
  localparam int TOG_BIT  = 6;
  localparam int STAT_LSB = 4;
  localparam int ADDR_LSB = 0;

  typedef enum logic [1:0] {
    EP_BULK = 2'b00,
    EP_CTRL = 2'b01,
    EP_ISO  = 2'b10,
    EP_INTR = 2'b11
  } ep_type_e;

  typedef enum logic [STAT_W-1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } tx_stat_e;
endpackage

// File: rtl/usb_ep_tog_unit.sv
module usb_ep_tog_unit
  import usb_ep_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ep_type_e ep_type_i,
  input  logic     ack_rcvd_i,
  input  logic     setup_rcvd_i,
  input  logic     iso_sent_i,
  input  logic     sw_flip_i,
  output logic     tog_o
);
  logic tog_q, hw_tog;
  logic is_iso, is_ctrl;

  assign is_iso  = (ep_type_i == EP_ISO);
  assign is_ctrl = (ep_type_i == EP_CTRL);

  // hardware result first, software inversion on top
  always_comb begin
    hw_tog = tog_q;
    if (is_ctrl && setup_rcvd_i)     hw_tog = 1'b1;
    else if (!is_iso && ack_rcvd_i)  hw_tog = ~tog_q;
    else if (is_iso && iso_sent_i)   hw_tog = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= hw_tog ^ sw_flip_i;
  end

  assign tog_o = tog_q;

  a_r5_setup_forces_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ctrl && setup_rcvd_i && !sw_flip_i) |=> tog_o);
  a_r4_ack_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_iso && ack_rcvd_i && !(is_ctrl && setup_rcvd_i) && !sw_flip_i)
      |=> (tog_o != $past(tog_o)));
  a_r6_iso_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_iso && !iso_sent_i && !sw_flip_i) |=> $stable(tog_o));
  a_r10_sw_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ctrl && setup_rcvd_i && sw_flip_i) |=> !tog_o);
endmodule

// File: rtl/usb_ep_stat_unit.sv
module usb_ep_stat_unit
  import usb_ep_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ep_type_e          ep_type_i,
  input  logic              host_mode_i,
  input  logic              xfer_ok_i,
  input  logic              hs_valid_i,
  input  logic [STAT_W-1:0] hs_code_i,
  input  logic [STAT_W-1:0] sw_flip_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, hw_stat;
  logic is_iso;

  assign is_iso = (ep_type_i == EP_ISO);

  always_comb begin
    hw_stat = stat_q;
    if (host_mode_i) begin
      if (hs_valid_i) hw_stat = hs_code_i;
    end else if (!is_iso && xfer_ok_i) begin
      hw_stat = ST_NAK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= ST_DIS;
    else         stat_q <= hw_stat ^ sw_flip_i;
  end

  assign stat_o = stat_q;

  a_r7_force_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && !is_iso && xfer_ok_i && sw_flip_i == '0) |=> (stat_o == ST_NAK));
  a_r8_iso_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && is_iso && sw_flip_i == '0) |=> $stable(stat_o));
  a_r9_host_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && hs_valid_i && sw_flip_i == '0) |=> (stat_o == $past(hs_code_i)));
  a_r9_host_no_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && !hs_valid_i && sw_flip_i == '0) |=> $stable(stat_o));
endmodule

// File: rtl/usb_ep_addr_reg.sv
module usb_ep_addr_reg
  import usb_ep_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_o <= '0;
    else if (wr_i) addr_o <= wdata_i;
  end

  a_r3_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (addr_o == $past(wdata_i)));
  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(addr_o));
endmodule

// File: rtl/usb_ep_tx_ctrl.sv
module usb_ep_tx_ctrl
  import usb_ep_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_be_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [1:0]        ep_type_i,
  input  logic              host_mode_i,
  input  logic              ack_rcvd_i,
  input  logic              setup_rcvd_i,
  input  logic              iso_sent_i,
  input  logic              xfer_ok_i,
  input  logic              hs_valid_i,
  input  logic [STAT_W-1:0] hs_code_i,
  output logic              dtog_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAD_W = REG_W - TOG_BIT - 1;

  logic              wr;
  logic              tog_flip;
  logic [STAT_W-1:0] stat_flip;
  ep_type_e          ep_type;

  assign wr        = reg_we_i & reg_be_i;
  assign ep_type   = ep_type_e'(ep_type_i);
  assign tog_flip  = wr & reg_wdata_i[TOG_BIT];
  assign stat_flip = {STAT_W{wr}} & reg_wdata_i[STAT_LSB +: STAT_W];

  usb_ep_tog_unit u_tog (
    .clk_i, .rst_ni,
    .ep_type_i    (ep_type),
    .ack_rcvd_i, .setup_rcvd_i, .iso_sent_i,
    .sw_flip_i    (tog_flip),
    .tog_o        (dtog_o)
  );

  usb_ep_stat_unit u_stat (
    .clk_i, .rst_ni,
    .ep_type_i    (ep_type),
    .host_mode_i, .xfer_ok_i, .hs_valid_i, .hs_code_i,
    .sw_flip_i    (stat_flip),
    .stat_o       (stat_o)
  );

  usb_ep_addr_reg u_addr (
    .clk_i, .rst_ni,
    .wr_i    (wr),
    .wdata_i (reg_wdata_i[ADDR_LSB +: ADDR_W]),
    .addr_o  (addr_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign reg_rdata_o = {{PAD_W{1'b0}}, dtog_o, stat_o, addr_o};
    end else begin : g_nopad
      assign reg_rdata_o = {dtog_o, stat_o, addr_o};
    end
  endgenerate

  a_r2_no_strobe_no_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_be_i && !ack_rcvd_i && !setup_rcvd_i && !iso_sent_i && !xfer_ok_i && !hs_valid_i)
      |=> $stable(reg_rdata_o));
  a_r11_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1] == 1'b0);
endmodule

// File: tb/sim_usb_ep_tx_ctrl.sv
module sim_usb_ep_tx_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0, reg_be_i = 0;
  logic [7:0] reg_wdata_i = 0, reg_rdata_o;
  logic [1:0] ep_type_i = 0;
  logic host_mode_i = 0, ack_rcvd_i = 0, setup_rcvd_i = 0, iso_sent_i = 0;
  logic xfer_ok_i = 0, hs_valid_i = 0;
  logic [1:0] hs_code_i = 0, stat_o;
  logic dtog_o;
  logic [3:0] addr_o;

  int checks = 0, errors = 0;
  int m_tog = 0, m_stat = 0, m_addr = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_ep_tx_ctrl u0 (.*);

  task automatic idle();
    reg_we_i = 0; reg_be_i = 0; reg_wdata_i = 0;
    ack_rcvd_i = 0; setup_rcvd_i = 0; iso_sent_i = 0;
    xfer_ok_i = 0; hs_valid_i = 0; hs_code_i = 0;
  endtask

  task automatic compare(input string tag);
    int exp;
    exp = m_tog * 64 + m_stat * 16 + m_addr;
    checks++;
    if (reg_rdata_o !== exp[7:0] || dtog_o !== m_tog[0] ||
        stat_o !== m_stat[1:0] || addr_o !== m_addr[3:0]) begin
      errors++;
      $display("FAIL %s rdata=%02h exp=%02h", tag, reg_rdata_o, exp[7:0]);
    end
  endtask

  // behavioural model evaluated from the requirements
  task automatic step(input string tag);
    int nt, ns, na;
    bit w;
    nt = m_tog; ns = m_stat; na = m_addr;
    w  = reg_we_i && reg_be_i;
    if (ep_type_i == 1 && setup_rcvd_i) nt = 1;
    else if (ep_type_i != 2 && ack_rcvd_i) nt = 1 - m_tog;
    else if (ep_type_i == 2 && iso_sent_i) nt = 1 - m_tog;
    if (host_mode_i) begin
      if (hs_valid_i) ns = hs_code_i;
    end else if (ep_type_i != 2 && xfer_ok_i) ns = 2;
    if (w) begin
      if (reg_wdata_i[6]) nt = 1 - nt;
      ns = ns ^ int'(reg_wdata_i[5:4]);
      na = reg_wdata_i[3:0];
    end
    @(posedge clk_i); #1;
    m_tog = nt; m_stat = ns; m_addr = na;
    compare(tag);
    idle();
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    reg_we_i = 1; reg_be_i = 1; reg_wdata_i = d;
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    #(CLK_PERIOD * 2 + 1);
    compare("R1 reset");
    rst_ni = 1;
    step("R1 hold");

    // R2/R3 software writes
    wr(8'h75, "R2 R3 flip all, addr 5");
    wr(8'h00, "R2 zero write keeps");
    wr(8'h10, "R2 flip stat bit0");
    reg_we_i = 1; reg_be_i = 0; reg_wdata_i = 8'h7F;
    step("R2 no strobe");
    wr(8'h0A, "R3 addr A");

    // R4 ack on bulk/interrupt/control
    ep_type_i = 0; ack_rcvd_i = 1; step("R4 bulk ack");
    ep_type_i = 3; ack_rcvd_i = 1; step("R4 intr ack");
    // R5 setup on control, priority over ack
    ep_type_i = 1; setup_rcvd_i = 1; ack_rcvd_i = 1; step("R5 setup+ack");
    ep_type_i = 0; setup_rcvd_i = 1; step("R5 setup bulk ignored");
    // R6 iso
    ep_type_i = 2; ack_rcvd_i = 1; step("R6 iso ack ignored");
    iso_sent_i = 1; step("R6 iso sent flips");
    iso_sent_i = 1; step("R6 iso sent flips again");
    // R8 iso status held
    wr(8'h30, "R2 set stat");
    xfer_ok_i = 1; step("R8 iso xfer keeps status");
    // R7 device nak
    ep_type_i = 0; xfer_ok_i = 1; step("R7 bulk nak");
    wr(8'h10, "R2 to VALID");
    ep_type_i = 1; xfer_ok_i = 1; setup_rcvd_i = 1; step("R7 R5 setup xfer");
    // R9 host
    host_mode_i = 1; ep_type_i = 0; xfer_ok_i = 1; step("R9 host no nak");
    hs_valid_i = 1; hs_code_i = 2'b01; step("R9 host stall");
    hs_valid_i = 1; hs_code_i = 2'b10; step("R9 host nak");
    // R10 same-cycle ordering
    host_mode_i = 0; ep_type_i = 1; setup_rcvd_i = 1;
    reg_we_i = 1; reg_be_i = 1; reg_wdata_i = 8'h40; step("R10 setup then flip");
    ep_type_i = 0; xfer_ok_i = 1;
    reg_we_i = 1; reg_be_i = 1; reg_wdata_i = 8'h13; step("R10 nak then flip");
    ack_rcvd_i = 1; reg_we_i = 1; reg_be_i = 1; reg_wdata_i = 8'h40;
    step("R10 ack and flip cancel");

    // R11 random mix, compared every clock
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ep_type_i    = lfsr[1:0];
      host_mode_i  = lfsr[2] & lfsr[9];
      ack_rcvd_i   = lfsr[3];
      setup_rcvd_i = lfsr[4] & lfsr[10];
      iso_sent_i   = lfsr[5];
      xfer_ok_i    = lfsr[6];
      hs_valid_i   = lfsr[7];
      hs_code_i    = lfsr[12:11];
      reg_we_i     = lfsr[8] & lfsr[13];
      reg_be_i     = lfsr[14] | lfsr[15];
      reg_wdata_i  = lfsr[23:16];
      step("R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule